// File: doc/BRIEF.md
# DLL Re-enable Sequencer

This block sits on the controller side of a DDR3-class memory channel. It moves the device from running with its DLL disabled to running with the DLL locked. It does this through a self-refresh window, so that the interface clock can be retuned while the device keeps its contents by itself. The controller raises a start request once the device is quiet: every bank is precharged, no timing is still pending and termination is off. From then on the sequencer owns the command bus, the bank and address fields, CKE and ODT.

The sequencer first parks ODT low. It then enters self-refresh and asks an external clock agent to change frequency. When the agent reports a stable clock, the sequencer waits and leaves self-refresh. It then writes the mode registers in a fixed order: DLL enable, DLL reset, then the new latency and recovery settings. A long calibration can follow as an option. The sequencer pulses ready only after every outstanding wait has run out, including the DLL lock time, which counts in parallel with the later steps. Every wait is a run-time cycle count. A count N places the next event max(N,2) cycles after the event that started the wait.

Top module: `dll_relock_seq`

## Requirements
- R1: The command codes are NOP=0, SRE=1, SRX=2, MRS=3 and ZQCL=4. After reset the outputs are cmd_o=NOP, cke_o=1, odt_o=0, freq_req_o=0, busy_o=0 and ready_o=0.
- R2: A start is taken only in idle while idle_ok_i is high. A start with idle_ok_i low is ignored, and so is a start during a running sequence: that sequence's timing is unchanged and no second sequence follows it.
- R3: While idle, odt_o repeats odt_req_i one cycle later. From the cycle after a start is taken, odt_o is low for exactly t_odtoff_i+1 cycles before the SRE cycle.
- R4: SRE is issued with cke_o low, and cke_o stays low up to the SRX cycle. freq_req_o rises max(t_cksre_i,2) cycles after SRE and holds until the first cycle in which freq_ack_i is high, inclusive.
- R5: SRX, with cke_o high, is issued max(t_cksrx_i,2) cycles after the cycle in which freq_ack_i was seen high.
- R6: max(t_xs_i,2) cycles after SRX, an MRS to bank 1 carries mr1_i with address bit 0 cleared, which enables the DLL.
- R7: max(t_mrd_i,2) cycles later, an MRS to bank 0 carries mr0_i with address bit 8 set, which resets the DLL and starts the lock count.
- R8: max(t_mrd_i,2) cycles later, an MRS to bank 2 carries mr2_i. max(t_mrd_i,2) cycles after that, an MRS to bank 0 carries mr0_i with bit 8 cleared. Successive MRS commands are never closer than t_mrd_i.
- R9: If zq_en_i was high when the start was taken, ZQCL with address bit 10 set is issued max(t_mod_i,2) cycles after the last MRS. Otherwise no ZQCL is issued.
- R10: ready_o pulses for one cycle, exactly at the later of two points: max(t_dllk_i,2) after the DLL-reset MRS, and max(t_zqoper_i,2) after ZQCL (or max(t_mod_i,2) after the last MRS when there is no ZQCL). The block is idle in the next cycle.
- R11: From SRX through the ready cycle, cke_o is high and odt_o is low in every cycle.
- R12: Every cycle other than the sequence commands carries NOP. A sequence issues exactly 6 commands, or 7 with ZQCL.
- R13: A wait count of 0 or 1 gives a spacing of 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to run the sequence |
| idle_ok_i | input | 1 | Device quiet: banks precharged, timings met, termination off |
| zq_en_i | input | 1 | Issue long calibration at the end (sampled at start) |
| odt_req_i | input | 1 | ODT level wanted by the controller while idle |
| freq_ack_i | input | 1 | Clock agent: new clock stable |
| t_odtoff_i | input | CNT_W | ODT turn-off latency in cycles |
| t_cksre_i | input | CNT_W | SRE to clock-change wait |
| t_cksrx_i | input | CNT_W | Stable clock to SRX wait |
| t_xs_i | input | CNT_W | SRX to first MRS wait |
| t_mrd_i | input | CNT_W | MRS to MRS wait |
| t_mod_i | input | CNT_W | Last MRS to next command wait |
| t_dllk_i | input | CNT_W | DLL lock time after DLL reset |
| t_zqoper_i | input | CNT_W | Long calibration time |
| mr0_i | input | ADDR_W | Mode register 0 value (latency, write recovery) |
| mr1_i | input | ADDR_W | Mode register 1 value |
| mr2_i | input | ADDR_W | Mode register 2 value (write latency) |
| freq_req_o | output | 1 | Request to the clock agent |
| cmd_o | output | 3 | Command code |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address field |
| cke_o | output | 1 | Clock enable pin |
| odt_o | output | 1 | On-die termination pin |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | One-cycle pulse: device ready with DLL locked |

## Verification
The bench measures the distance in cycles between every pair of neighbouring events. It uses three timing sets. In one the DLL lock time dominates ready. In one the calibration wait dominates. In one every wait is 0 or 1, so the two-cycle floor applies. A design that started the lock count at the wrong MRS, or waited only for the stage-local timer, would raise ready early. A design with an off-by-one wait reload would shift a spacing by one cycle. The bench also pokes start in the middle of a run and while idle_ok_i is low. A design that accepted either pulse would restart, move the later commands, or stay busy after ready. It checks the mode-register words both with bit 8 already set in mr0_i and with it clear. A forced-bit error would show up either as a final MR0 that still resets the DLL or as a DLL reset that never sets the bit. It counts cycles with CKE low or ODT high after SRX, so any glitch inside the lock window is caught.

// File: rtl/dllseq_pkg.sv
package dllseq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_SRE  = 3'd1,
    CMD_SRX  = 3'd2,
    CMD_MRS  = 3'd3,
    CMD_ZQCL = 3'd4
  } dram_cmd_e;

  typedef enum logic [4:0] {
    S_IDLE,
    S_ODTQ,
    S_SRE,
    S_CKSRE,
    S_FREQ,
    S_CKSRX,
    S_SRX,
    S_XSW,
    S_MR1,
    S_MRDA,
    S_DLLRST,
    S_MRDB,
    S_MR2,
    S_MRDC,
    S_MR0,
    S_MODW,
    S_ZQ,
    S_ZQW,
    S_DLLKW,
    S_DONE
  } seq_state_e;

  // address bits with a fixed meaning in the mode-register words
  localparam int DLL_EN_BIT  = 0;
  localparam int DLL_RST_BIT = 8;
  localparam int ZQ_LONG_BIT = 10;

  // bank address selecting each mode register
  localparam int MR0_BA = 0;
  localparam int MR1_BA = 1;
  localparam int MR2_BA = 2;

endpackage

// File: rtl/dllseq_timer.sv
// Down-counter loaded on entry to a wait. done_o is high once at most one
// cycle remains, so a load of L ends the wait L+1 cycles after the load edge.
module dllseq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q <= CNT_W'(1));

endmodule

// File: rtl/dllseq_out_dec.sv
// Maps a sequencer state to the pin values driven during that state.
module dllseq_out_dec
  import dllseq_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3
) (
  input  seq_state_e        st_i,
  input  logic              odt_req_i,
  input  logic [ADDR_W-1:0] mr0_i,
  input  logic [ADDR_W-1:0] mr1_i,
  input  logic [ADDR_W-1:0] mr2_i,
  output dram_cmd_e         cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cke_o,
  output logic              odt_o,
  output logic              freq_req_o,
  output logic              busy_o,
  output logic              ready_o
);

  localparam logic [ADDR_W-1:0] EN_MASK  = ADDR_W'(1) << DLL_EN_BIT;
  localparam logic [ADDR_W-1:0] RST_MASK = ADDR_W'(1) << DLL_RST_BIT;
  localparam logic [ADDR_W-1:0] ZQ_MASK  = ADDR_W'(1) << ZQ_LONG_BIT;

  always_comb begin
    cmd_o      = CMD_NOP;
    ba_o       = '0;
    addr_o     = '0;
    cke_o      = 1'b1;
    odt_o      = 1'b0;
    freq_req_o = 1'b0;
    busy_o     = 1'b1;
    ready_o    = 1'b0;
    unique case (st_i)
      S_IDLE: begin
        busy_o = 1'b0;
        odt_o  = odt_req_i;
      end
      S_SRE: begin
        cmd_o = CMD_SRE;
        cke_o = 1'b0;
      end
      S_CKSRE, S_CKSRX: cke_o = 1'b0;
      S_FREQ: begin
        cke_o      = 1'b0;
        freq_req_o = 1'b1;
      end
      S_SRX: cmd_o = CMD_SRX;
      S_MR1: begin
        cmd_o  = CMD_MRS;
        ba_o   = BA_W'(MR1_BA);
        addr_o = mr1_i & ~EN_MASK;
      end
      S_DLLRST: begin
        cmd_o  = CMD_MRS;
        ba_o   = BA_W'(MR0_BA);
        addr_o = mr0_i | RST_MASK;
      end
      S_MR2: begin
        cmd_o  = CMD_MRS;
        ba_o   = BA_W'(MR2_BA);
        addr_o = mr2_i;
      end
      S_MR0: begin
        cmd_o  = CMD_MRS;
        ba_o   = BA_W'(MR0_BA);
        addr_o = mr0_i & ~RST_MASK;
      end
      S_ZQ: begin
        cmd_o  = CMD_ZQCL;
        addr_o = ZQ_MASK;
      end
      S_DONE: begin
        busy_o  = 1'b0;
        ready_o = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dll_relock_seq.sv
module dll_relock_seq
  import dllseq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              idle_ok_i,
  input  logic              zq_en_i,
  input  logic              odt_req_i,
  input  logic              freq_ack_i,
  input  logic [CNT_W-1:0]  t_odtoff_i,
  input  logic [CNT_W-1:0]  t_cksre_i,
  input  logic [CNT_W-1:0]  t_cksrx_i,
  input  logic [CNT_W-1:0]  t_xs_i,
  input  logic [CNT_W-1:0]  t_mrd_i,
  input  logic [CNT_W-1:0]  t_mod_i,
  input  logic [CNT_W-1:0]  t_dllk_i,
  input  logic [CNT_W-1:0]  t_zqoper_i,
  input  logic [ADDR_W-1:0] mr0_i,
  input  logic [ADDR_W-1:0] mr1_i,
  input  logic [ADDR_W-1:0] mr2_i,
  output logic              freq_req_o,
  output logic [2:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cke_o,
  output logic              odt_o,
  output logic              busy_o,
  output logic              ready_o
);

  seq_state_e       st_q, st_n;
  logic             zq_q;
  logic             step_ld, step_done;
  logic [CNT_W-1:0] step_val;
  logic             dllk_ld, dllk_done;

  // load value for a spacing of n cycles from the current edge
  function automatic logic [CNT_W-1:0] gap(input logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  dllseq_timer #(.CNT_W(CNT_W)) u_step (
    .clk       (clk),
    .rst       (rst),
    .load_i    (step_ld),
    .load_val_i(step_val),
    .done_o    (step_done)
  );

  // lock count runs beside the later MRS and calibration steps
  dllseq_timer #(.CNT_W(CNT_W)) u_dllk (
    .clk       (clk),
    .rst       (rst),
    .load_i    (dllk_ld),
    .load_val_i(gap(t_dllk_i)),
    .done_o    (dllk_done)
  );

  always_comb begin
    st_n     = st_q;
    step_ld  = 1'b0;
    step_val = '0;
    dllk_ld  = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i && idle_ok_i) begin
        st_n     = S_ODTQ;
        step_ld  = 1'b1;
        step_val = t_odtoff_i + 1'b1;
      end
      S_ODTQ:  if (step_done) st_n = S_SRE;
      S_SRE: begin
        st_n     = S_CKSRE;
        step_ld  = 1'b1;
        step_val = gap(t_cksre_i);
      end
      S_CKSRE: if (step_done) st_n = S_FREQ;
      S_FREQ: if (freq_ack_i) begin
        st_n     = S_CKSRX;
        step_ld  = 1'b1;
        step_val = gap(t_cksrx_i);
      end
      S_CKSRX: if (step_done) st_n = S_SRX;
      S_SRX: begin
        st_n     = S_XSW;
        step_ld  = 1'b1;
        step_val = gap(t_xs_i);
      end
      S_XSW:   if (step_done) st_n = S_MR1;
      S_MR1: begin
        st_n     = S_MRDA;
        step_ld  = 1'b1;
        step_val = gap(t_mrd_i);
      end
      S_MRDA:  if (step_done) st_n = S_DLLRST;
      S_DLLRST: begin
        st_n     = S_MRDB;
        step_ld  = 1'b1;
        step_val = gap(t_mrd_i);
        dllk_ld  = 1'b1;
      end
      S_MRDB:  if (step_done) st_n = S_MR2;
      S_MR2: begin
        st_n     = S_MRDC;
        step_ld  = 1'b1;
        step_val = gap(t_mrd_i);
      end
      S_MRDC:  if (step_done) st_n = S_MR0;
      S_MR0: begin
        st_n     = S_MODW;
        step_ld  = 1'b1;
        step_val = gap(t_mod_i);
      end
      S_MODW: if (step_done) begin
        if (zq_q)           st_n = S_ZQ;
        else if (dllk_done) st_n = S_DONE;
        else                st_n = S_DLLKW;
      end
      S_ZQ: begin
        st_n     = S_ZQW;
        step_ld  = 1'b1;
        step_val = gap(t_zqoper_i);
      end
      S_ZQW:   if (step_done) st_n = dllk_done ? S_DONE : S_DLLKW;
      S_DLLKW: if (dllk_done) st_n = S_DONE;
      S_DONE:  st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_IDLE;
      zq_q <= 1'b0;
    end else begin
      st_q <= st_n;
      if (st_q == S_IDLE && start_i && idle_ok_i) zq_q <= zq_en_i;
    end
  end

  // pin values decoded from the next state, then registered
  dram_cmd_e         cmd_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;
  logic              cke_d, odt_d, freq_d, busy_d, ready_d;

  dllseq_out_dec #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_dec (
    .st_i      (st_n),
    .odt_req_i (odt_req_i),
    .mr0_i     (mr0_i),
    .mr1_i     (mr1_i),
    .mr2_i     (mr2_i),
    .cmd_o     (cmd_d),
    .ba_o      (ba_d),
    .addr_o    (addr_d),
    .cke_o     (cke_d),
    .odt_o     (odt_d),
    .freq_req_o(freq_d),
    .busy_o    (busy_d),
    .ready_o   (ready_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o      <= CMD_NOP;
      ba_o       <= '0;
      addr_o     <= '0;
      cke_o      <= 1'b1;
      odt_o      <= 1'b0;
      freq_req_o <= 1'b0;
      busy_o     <= 1'b0;
      ready_o    <= 1'b0;
    end else begin
      cmd_o      <= cmd_d;
      ba_o       <= ba_d;
      addr_o     <= addr_d;
      cke_o      <= cke_d;
      odt_o      <= odt_d;
      freq_req_o <= freq_d;
      busy_o     <= busy_d;
      ready_o    <= ready_d;
    end
  end

endmodule

// File: rtl/dll_relock_seq_chk.sv
module dll_relock_seq_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        cmd_o,
  input logic [BA_W-1:0]   ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              cke_o,
  input logic              odt_o,
  input logic              freq_req_o,
  input logic              freq_ack_i,
  input logic              ready_o,
  input logic [CNT_W-1:0]  t_mrd_i
);

  logic             in_lock_q;
  logic             mrs_seen_q;
  logic [CNT_W-1:0] since_mrs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_lock_q   <= 1'b0;
      mrs_seen_q  <= 1'b0;
      since_mrs_q <= '0;
    end else begin
      if (cmd_o == 3'd2) in_lock_q <= 1'b1;
      else if (ready_o)  in_lock_q <= 1'b0;
      if (cmd_o == 3'd3) begin
        mrs_seen_q  <= 1'b1;
        since_mrs_q <= CNT_W'(1);
      end else begin
        if (ready_o) mrs_seen_q <= 1'b0;
        if (since_mrs_q != '1) since_mrs_q <= since_mrs_q + 1'b1;
      end
    end
  end

  // R4
  sre_cke_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'd1) |-> !cke_o);

  // R4
  freq_in_sr_chk: assert property (@(posedge clk) disable iff (rst)
    freq_req_o |-> !cke_o);

  // R4
  freq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (freq_req_o && !freq_ack_i) |=> freq_req_o);

  // R5
  srx_cke_high_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'd2) |-> cke_o);

  // R6
  dll_enable_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'd3 && ba_o == BA_W'(1)) |-> !addr_o[0]);

  // R8
  mrs_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'd3 && mrs_seen_q) |-> (since_mrs_q >= t_mrd_i));

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> !ready_o);

  // R11
  lock_window_chk: assert property (@(posedge clk) disable iff (rst)
    in_lock_q |-> (cke_o && !odt_o));

endmodule

bind dll_relock_seq dll_relock_seq_chk #(
  .CNT_W (CNT_W),
  .ADDR_W(ADDR_W),
  .BA_W  (BA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_o     (cmd_o),
  .ba_o      (ba_o),
  .addr_o    (addr_o),
  .cke_o     (cke_o),
  .odt_o     (odt_o),
  .freq_req_o(freq_req_o),
  .freq_ack_i(freq_ack_i),
  .ready_o   (ready_o),
  .t_mrd_i   (t_mrd_i)
);

// File: tb/dll_relock_seq_bench.sv
`timescale 1ns/1ps
module dll_relock_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, idle_ok_i = 1'b0, zq_en_i = 1'b0;
  logic        odt_req_i = 1'b0, freq_ack_i = 1'b0;
  logic [15:0] t_odtoff_i = '0, t_cksre_i = '0, t_cksrx_i = '0, t_xs_i = '0;
  logic [15:0] t_mrd_i = '0, t_mod_i = '0, t_dllk_i = '0, t_zqoper_i = '0;
  logic [13:0] mr0_i = '0, mr1_i = '0, mr2_i = '0;
  logic        freq_req_o, cke_o, odt_o, busy_o, ready_o;
  logic [2:0]  cmd_o, ba_o;
  logic [13:0] addr_o;

  int n_tests = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  dll_relock_seq u_dll_relock_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .idle_ok_i(idle_ok_i),
    .zq_en_i(zq_en_i), .odt_req_i(odt_req_i), .freq_ack_i(freq_ack_i),
    .t_odtoff_i(t_odtoff_i), .t_cksre_i(t_cksre_i), .t_cksrx_i(t_cksrx_i),
    .t_xs_i(t_xs_i), .t_mrd_i(t_mrd_i), .t_mod_i(t_mod_i),
    .t_dllk_i(t_dllk_i), .t_zqoper_i(t_zqoper_i),
    .mr0_i(mr0_i), .mr1_i(mr1_i), .mr2_i(mr2_i),
    .freq_req_o(freq_req_o), .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o),
    .cke_o(cke_o), .odt_o(odt_o), .busy_o(busy_o), .ready_o(ready_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung (act %0d cycles, exp < 150000)", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
    end
  endtask

  function automatic int mx(input int n);
    return (n < 2) ? 2 : n;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R1: reset values
  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(cmd_o == 3'd0, "R1", "cmd NOP", cmd_o, 0);
    check(cke_o == 1'b1, "R1", "cke high", cke_o, 1);
    check(odt_o == 1'b0 && freq_req_o == 1'b0, "R1", "odt/freq low",
          {odt_o, freq_req_o}, 0);
    check(busy_o == 1'b0 && ready_o == 1'b0, "R1", "busy/ready low",
          {busy_o, ready_o}, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // R3: odt passthrough while idle
  task automatic t_odt_pass();
    odt_req_i = 1'b1;
    @(negedge clk);
    check(odt_o == 1'b1, "R3", "odt follows req high", odt_o, 1);
    odt_req_i = 1'b0;
    @(negedge clk);
    check(odt_o == 1'b0, "R3", "odt follows req low", odt_o, 0);
  endtask

  // R2: start without idle_ok ignored
  task automatic t_not_idle();
    int bad = 0;
    idle_ok_i = 1'b0;
    start_i = 1'b1;
    repeat (3) @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (busy_o || cmd_o != 3'd0 || !cke_o) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R2", "start ignored with idle_ok low", bad, 0);
  endtask

  task automatic run_seq(input string tag, input int odtoff, input int cksre,
                         input int cksrx, input int xs, input int mrd,
                         input int mdd, input int dllk, input int zqo,
                         input bit zq, input int ackdly, input bit poke,
                         input logic [13:0] mr0, input logic [13:0] mr1,
                         input logic [13:0] mr2);
    int c_low = -1, c_sre = -1, c_freq = -1, c_ack = -1, c_srx = -1;
    int c_mr1 = -1, c_dll = -1, c_mr2 = -1, c_mr0 = -1, c_zq = -1, c_rdy = -1;
    int ncmd = 0, cke_low = 0, freq_hi = 0, win_bad = 0, post_bad = 0;
    int exp_rdy;
    logic [13:0] a_mr1 = '0, a_dll = '0, a_mr2 = '0, a_mr0 = '0, a_zq = '0;
    t_odtoff_i = 16'(odtoff); t_cksre_i = 16'(cksre); t_cksrx_i = 16'(cksrx);
    t_xs_i = 16'(xs); t_mrd_i = 16'(mrd); t_mod_i = 16'(mdd);
    t_dllk_i = 16'(dllk); t_zqoper_i = 16'(zqo);
    zq_en_i = zq; mr0_i = mr0; mr1_i = mr1; mr2_i = mr2;
    odt_req_i = 1'b1;
    idle_ok_i = 1'b1;
    repeat (3) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    odt_req_i = 1'b0;
    for (int k = 0; k < 20000 && c_rdy < 0; k++) begin
      if (c_low < 0 && !odt_o) c_low = cyc;
      if (cmd_o != 3'd0) ncmd++;
      if (!cke_o) cke_low++;
      if (freq_req_o) freq_hi++;
      if (c_srx >= 0 && (!cke_o || odt_o)) win_bad++;
      case (cmd_o)
        3'd1: c_sre = cyc;
        3'd2: c_srx = cyc;
        3'd3: begin
          if (ba_o == 3'd1) begin c_mr1 = cyc; a_mr1 = addr_o; end
          else if (ba_o == 3'd2) begin c_mr2 = cyc; a_mr2 = addr_o; end
          else if (c_dll < 0) begin c_dll = cyc; a_dll = addr_o; end
          else begin c_mr0 = cyc; a_mr0 = addr_o; end
        end
        3'd4: begin c_zq = cyc; a_zq = addr_o; end
        default: ;
      endcase
      if (freq_req_o && c_freq < 0) c_freq = cyc;
      if (c_freq >= 0 && c_ack < 0 && cyc - c_freq >= ackdly) begin
        freq_ack_i = 1'b1;
        c_ack = cyc;
      end else if (c_ack >= 0 && !freq_req_o) begin
        freq_ack_i = 1'b0;
      end
      start_i = (poke && c_srx >= 0 && cyc == c_srx + 1);
      if (ready_o) c_rdy = cyc;
      else @(negedge clk);
    end
    freq_ack_i = 1'b0;
    start_i = 1'b0;
    check(c_rdy >= 0, "R10", {tag, " ready seen"}, c_rdy, 1);
    check(c_sre - c_low == odtoff + 1, "R3", {tag, " odt quiet before SRE"},
          c_sre - c_low, odtoff + 1);
    check(c_freq - c_sre == mx(cksre), "R4", {tag, " SRE to freq_req"},
          c_freq - c_sre, mx(cksre));
    check(freq_hi == ackdly + 1, "R4", {tag, " freq_req held until ack"},
          freq_hi, ackdly + 1);
    check(cke_low == c_srx - c_sre, "R4", {tag, " cke low SRE..SRX"},
          cke_low, c_srx - c_sre);
    check(c_srx - c_ack == mx(cksrx), "R5", {tag, " ack to SRX"},
          c_srx - c_ack, mx(cksrx));
    check(c_mr1 - c_srx == mx(xs), "R6", {tag, " SRX to MR1"},
          c_mr1 - c_srx, mx(xs));
    check(a_mr1 == (mr1 & ~14'h0001), "R6", {tag, " MR1 word"},
          a_mr1, mr1 & ~14'h0001);
    check(c_dll - c_mr1 == mx(mrd), "R7", {tag, " MR1 to DLL reset"},
          c_dll - c_mr1, mx(mrd));
    check(a_dll == (mr0 | 14'h0100), "R7", {tag, " DLL reset word"},
          a_dll, mr0 | 14'h0100);
    check(c_mr2 - c_dll == mx(mrd) && c_mr0 - c_mr2 == mx(mrd), "R8",
          {tag, " MR2/MR0 spacing"}, c_mr0 - c_dll, 2 * mx(mrd));
    check(a_mr2 == mr2 && a_mr0 == (mr0 & ~14'h0100), "R8",
          {tag, " MR2/MR0 words"}, a_mr0, mr0 & ~14'h0100);
    if (zq) begin
      check(c_zq - c_mr0 == mx(mdd), "R9", {tag, " last MRS to ZQCL"},
            c_zq - c_mr0, mx(mdd));
      check(a_zq[10] == 1'b1, "R9", {tag, " ZQCL long bit"}, a_zq[10], 1);
      exp_rdy = imax(c_zq + mx(zqo), c_dll + mx(dllk));
    end else begin
      check(c_zq == -1, "R9", {tag, " no ZQCL"}, c_zq, -1);
      exp_rdy = imax(c_mr0 + mx(mdd), c_dll + mx(dllk));
    end
    check(c_rdy == exp_rdy, "R10", {tag, " ready cycle"}, c_rdy, exp_rdy);
    check(win_bad == 0, "R11", {tag, " cke/odt in lock window"}, win_bad, 0);
    check(ncmd == (zq ? 7 : 6), "R12", {tag, " command count"}, ncmd,
          zq ? 7 : 6);
    @(negedge clk);
    check(!ready_o && !busy_o, "R10", {tag, " idle after ready"},
          {ready_o, busy_o}, 0);
    for (int k = 0; k < 4; k++) begin
      if (cmd_o != 3'd0 || busy_o) post_bad++;
      @(negedge clk);
    end
    check(post_bad == 0, "R2", {tag, " no restart after ready"}, post_bad, 0);
  endtask

  initial begin
    t_reset();
    t_odt_pass();
    t_not_idle();
    // lock time dominates ready
    run_seq("dllk", 3, 5, 4, 10, 4, 12, 60, 0, 1'b0, 3, 1'b0,
            14'h0A30, 14'h0045, 14'h0018);
    // calibration dominates, start poked mid-run, bit 8 preset in mr0
    run_seq("zq", 5, 6, 7, 9, 5, 8, 20, 40, 1'b1, 0, 1'b1,
            14'h1D14, 14'h0004, 14'h0020);
    // R13: all waits 0 or 1 use the two-cycle floor
    run_seq("min", 0, 0, 1, 0, 1, 0, 0, 1, 1'b1, 2, 1'b0,
            14'h0123, 14'h3FFF, 14'h0008);
    check(n_tests > 12, "R13", "minimum-wait scenario completed", n_tests, 13);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule